// File: doc/BRIEF.md
# Nine-bit Galois pseudo-random generator with resynchronized reset

The block produces a stream of nine-bit pseudo-random words, one new word per clock. It is a Galois (internal-XOR) shift register: on every rising edge the state moves one place toward its most significant bit. The bit that falls off the top feeds back into bit 0 and is also XORed into bits 2, 3 and 4 on their way up. The feedback word is therefore 0x01D.

The reset input is treated as a raw, unsynchronized pin. Two flip-flops resample it. The second of them acts as an active-high synchronous reset that loads the seed 0x100, with only the top bit set. The output port is a register that copies the state every cycle, so it lags the state by one clock. Consumers take the output word as it is and see a fixed, repeatable sequence after every reset.

Top module: `lfsr_galois9`

## Requirements
- R1: When not in reset, each state bit 1 and 5 through 8 takes the value that its lower neighbour held one cycle earlier.
- R2: When not in reset, state bit 0 takes the value that bit 8 held one cycle earlier.
- R3: When not in reset, state bits 2, 3 and 4 take their lower neighbour (bits 1, 2 and 3) XORed with the previous bit 8. Stepping from 0x100 therefore gives 0x01D, and the next step gives 0x03A.
- R4: While the synchronized reset is high, the state loads the seed 0x100 (only bit 8 set).
- R5: Suppose the raw reset is first sampled high at edge n. The state holds the seed after edge n+2, and `rnd_o` reads 0x100 after edge n+3. Before that, `rnd_o` keeps following the stepping sequence.
- R6: Suppose the raw reset is first sampled low at edge m after a long reset. `rnd_o` reads 0x100 after edge m+2, 0x01D after edge m+3 and 0x03A after edge m+4.
- R7: `rnd_o` after any edge equals the state as it stood before that edge.
- R8: Once the seed has been loaded, the state and `rnd_o` never read zero.
- R9: A raw reset pulse that is sampled high at exactly one edge still reseeds the generator. `rnd_o` reads 0x100 three edges later and 0x01D four edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every register updates on its rising edge |
| rst_raw_i | input | 1 | Raw active-high reset pin, may be asynchronous to clk_i |
| rnd_o | output | 9 | Registered pseudo-random word |

## Verification
The bound checker watches the following on every cycle: the per-bit shift and feedback relations, the seed load under synchronized reset, the two-cycle lag of the synchronized reset behind the pin, the one-cycle lag of the output behind the state, and the absence of the all-zero word. Only the bench scenarios can show the end-to-end latencies at the port: the reset reaches the output three edges after the pin asserts, and stepping resumes with 0x01D three edges after release. The same applies to a single-cycle reset pulse being caught, and to the full word sequence matching an independent arithmetic model over a long run.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  // Default geometry of the generator
  localparam int unsigned LFSR_W      = 9;
  localparam logic [8:0]  LFSR_TAPS   = 9'h01D;  // bits fed by the top bit
  localparam logic [8:0]  LFSR_SEED   = 9'h100;  // value loaded on reset
  localparam int unsigned SYNC_DEPTH  = 2;       // reset resampling stages
endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync #(
  parameter int unsigned STAGES = lfsr_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic raw_i,
  output logic sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] pipe_d;
  logic [STAGES-1:0] pipe_q;

  // next-state: shift the pin sample into the chain
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign pipe_d[s] = raw_i;
      end else begin : g_rest
        assign pipe_d[s] = pipe_q[s-1];
      end
    end
  endgenerate

  // register
  always_ff @(posedge clk_i) begin
    pipe_q <= pipe_d;
  end

  assign sync_o = pipe_q[LAST];
endmodule

// File: rtl/lfsr_galois_next.sv
module lfsr_galois_next #(
  parameter int unsigned   W    = lfsr_pkg::LFSR_W,
  parameter logic [W-1:0]  TAPS = lfsr_pkg::LFSR_TAPS
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  localparam int unsigned TOP = W - 1;

  logic fb;
  assign fb = cur_i[TOP];

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == 0) begin : g_low
        assign nxt_o[b] = TAPS[b] & fb;
      end else if (TAPS[b]) begin : g_tap
        assign nxt_o[b] = cur_i[b-1] ^ fb;
      end else begin : g_plain
        assign nxt_o[b] = cur_i[b-1];
      end
    end
  endgenerate
endmodule

// File: rtl/lfsr_galois9.sv
module lfsr_galois9 #(
  parameter int unsigned          WIDTH  = lfsr_pkg::LFSR_W,
  parameter logic [WIDTH-1:0]     TAPS   = lfsr_pkg::LFSR_TAPS,
  parameter logic [WIDTH-1:0]     SEED   = lfsr_pkg::LFSR_SEED,
  parameter int unsigned          STAGES = lfsr_pkg::SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_raw_i,
  output logic [WIDTH-1:0] rnd_o
);
  logic             rst_sync;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] step_w;
  logic [WIDTH-1:0] rnd_q;

  lfsr_rst_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .raw_i  (rst_raw_i),
    .sync_o (rst_sync)
  );

  lfsr_galois_next #(.W(WIDTH), .TAPS(TAPS)) u_next (
    .cur_i (state_q),
    .nxt_o (step_w)
  );

  // next-state: synchronous seed load has priority over stepping
  always_comb begin
    if (rst_sync) begin
      state_d = SEED;
    end else begin
      state_d = step_w;
    end
  end

  // registers: state and its output copy
  always_ff @(posedge clk_i) begin
    state_q <= state_d;
    rnd_q   <= state_q;
  end

  assign rnd_o = rnd_q;
endmodule

// File: rtl/lfsr_galois9_chk.sv
module lfsr_galois9_chk #(
  parameter int unsigned W = 9
) (
  input logic         clk,
  input logic         rst_raw,
  input logic         rst_s,
  input logic [W-1:0] state,
  input logic [W-1:0] rnd
);
  // armed once the synchronized reset has been seen
  logic armed;
  always_ff @(posedge clk) begin
    armed <= armed | rst_s;
  end

  p_shift_r1: assert property (@(posedge clk) disable iff (!armed)
    !rst_s |=> (state[8:5] == $past(state[7:4])) && (state[1] == $past(state[0])))
    else $error("R1 shift relation broken");

  p_wrap_r2: assert property (@(posedge clk) disable iff (!armed)
    !rst_s |=> state[0] == $past(state[8]))
    else $error("R2 bit0 feedback broken");

  p_xor_r3: assert property (@(posedge clk) disable iff (!armed)
    !rst_s |=> state[4:2] == ($past(state[3:1]) ^ {3{$past(state[8])}}))
    else $error("R3 tap XOR broken");

  p_seed_r4: assert property (@(posedge clk) disable iff (!armed)
    rst_s |=> state == 9'h100)
    else $error("R4 seed not loaded");

  p_sync_lag_r5: assert property (@(posedge clk) disable iff (!armed)
    $past(rst_raw, 2) == rst_s)
    else $error("R5 reset lag wrong");

  p_copy_r7: assert property (@(posedge clk) disable iff (!armed)
    rnd == $past(state))
    else $error("R7 output not a one-cycle copy");

  p_nonzero_r8: assert property (@(posedge clk) disable iff (!armed)
    state != '0)
    else $error("R8 state reached zero");
endmodule

bind lfsr_galois9 lfsr_galois9_chk #(.W(WIDTH)) u_chk (
  .clk     (clk_i),
  .rst_raw (rst_raw_i),
  .rst_s   (rst_sync),
  .state   (state_q),
  .rnd     (rnd_o)
);

// File: tb/lfsr_galois9_tb.sv
module lfsr_galois9_tb;
  logic       clk;
  logic       rst_raw;
  logic [8:0] rnd;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  lfsr_galois9 u_dut (
    .clk_i     (clk),
    .rst_raw_i (rst_raw),
    .rnd_o     (rnd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // ---------------- reference model ----------------
  function automatic int step_f(int s);
    int n;
    n = (s << 1) & 511;
    if (((s >> 8) & 1) == 1) n = n ^ 29;  // taps into bits 0,2,3,4
    return n;
  endfunction

  int  rq[$];          // raw reset samples of the last two edges
  int  m_state = 0;
  int  m_out   = 0;
  bit  st_ok   = 0;
  bit  out_ok  = 0;

  always @(posedge clk) begin
    int eff;
    eff = (rq.size() == 2) ? rq[0] : 0;
    m_out = m_state;
    out_ok = st_ok;
    if (eff == 1) begin
      m_state = 256;
      st_ok = 1;
    end else begin
      m_state = step_f(m_state);
    end
    rq.push_back(int'(rst_raw));
    if (rq.size() > 2) void'(rq.pop_front());
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (out_ok && !done) begin
      checks++;
      if (int'(rnd) != m_out) begin
        errors++;
        $display("FAIL R1/R2/R3/R7 model compare: actual %h expected %h", rnd, m_out[8:0]);
      end
    end
  end

  task automatic chk(string req, int exp);
    checks++;
    if (int'(rnd) != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, rnd, exp[8:0]);
    end
  endtask

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_raw = 1'b1;
    wait_neg(8);
    chk("R4 reset state", 256);
    // release: raw low before edge m
    rst_raw = 1'b0;
    wait_neg(3); chk("R6 seed held after m+2", 256);
    wait_neg(1); chk("R6 R2 R3 first step", 29);
    wait_neg(1); chk("R6 R3 second step", 58);
    // long run: never zero
    begin
      int zeros;
      zeros = 0;
      for (int i = 0; i < 600; i++) begin
        wait_neg(1);
        if (rnd == 9'd0) zeros++;
      end
      chk("R8 zero words seen", 256 - 256 + zeros == 0 ? int'(rnd) : -1);
      checks++;
      if (zeros != 0) begin
        errors++;
        $display("FAIL R8: actual %0d zero words expected 0", zeros);
      end
    end
    // assertion during run: raw high before edge n
    rst_raw = 1'b1;
    begin
      int pre;
      wait_neg(3);
      pre = int'(rnd);
      checks++;
      if (pre != m_out) begin
        errors++;
        $display("FAIL R5 output before seed: actual %h expected %h", rnd, m_out[8:0]);
      end
      wait_neg(1); chk("R5 seed at output after n+3", 256);
    end
    wait_neg(4);
    rst_raw = 1'b0;
    wait_neg(6);
    // one-cycle pulse
    rst_raw = 1'b1;
    wait_neg(1);
    rst_raw = 1'b0;
    wait_neg(3); chk("R9 pulse seed", 256);
    wait_neg(1); chk("R9 pulse resumes", 29);
    wait_neg(20);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule